// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events from a row of peripheral sources and turns them into a single service request for the CPU, together with the address of the vector the CPU must fetch. Each source owns a sticky flag, which a one-cycle event pulse sets and software clears by writing 1 to its bit. Each source also has a local enable bit. A source only asks for service when its flag and its enable are both set and its global gate is open.

Sources are numbered by slot. Slot k owns vector address 0xFFFE - 2*k, so a lower slot means a higher vector and a higher priority. Slots 0 to 4 cannot be masked. Slot 5 is gated by the X mask input. Slot 6 and every slot above it are gated by the I mask input. A priority-raise register names one I-gated source by the low byte of its vector. That source then outranks every other I-gated source. The CPU pulses an acknowledge, and the block latches the winning vector so that it stays steady while the CPU fetches it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the flag and enable registers read 0, the priority-raise register reads 0x00F2, `irq_req` is 0 and `irq_vec` is 0xFFFE.
- R2: A 1 on `evt[k]` sets flag k at the next clock edge. A flag stays set until a write to address 0 carries a 1 in bit k. Writing 0 leaves the flag unchanged. If a set and a clear reach the same flag in the same cycle, the set wins.
- R3: A write to address 1 loads the enable register. Bit k enables slot k.
- R4: `irq_req` is high exactly when some slot has its flag and its enable set and its gate open. The gate is always open for slots 0 to 4. It is open for slot 5 while `x_mask` is 0, and for slots 6 and up while `i_mask` is 0.
- R5: When `irq_ack` and `irq_req` are both high at a clock edge, `irq_vec` takes the value 0xFFFE - 2*w after that edge. Here w is the requesting slot of lowest index, unless R6 applies.
- R6: The priority-raise register (address 2, low 8 bits) is valid when it holds an even value V for which (0xFE - V)/2 is a slot from 6 to NUM_SRC-1. When it is valid, that slot is requesting, and no slot from 0 to 5 is requesting, that slot wins.
- R7: An invalid priority-raise value (odd, naming slot 5 or below, or naming a slot beyond NUM_SRC-1) is read back as written but leaves the fixed order unchanged.
- R8: Writes to the priority-raise register take effect only while `i_mask` is 1. Otherwise they are dropped.
- R9: `rd_data` is registered. One cycle after `reg_addr` is presented it shows address 0 = flags, 1 = enables, 2 = priority-raise value zero-extended, 3 = zero.
- R10: `irq_vec` changes only at an edge where `irq_ack` and `irq_req` are both high. An acknowledge while nothing requests leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | NUM_SRC | Per-slot event pulses that set the flags |
| i_mask | input | 1 | Global mask for slots 6 and up (1 = masked) |
| x_mask | input | 1 | Mask for slot 5 (1 = masked) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | NUM_SRC | Register write data |
| rd_data | output | NUM_SRC | Registered read data |
| irq_ack | input | 1 | CPU acknowledge; latches the winning vector |
| irq_req | output | 1 | Service request to the CPU |
| irq_vec | output | 16 | Latched vector address |

## Verification
Directed sequences first set up a single pending source, which separates the gating of the three slot groups. They then set several pending sources at once, which shows whether the fixed order picks the lowest slot. Raising a low-ranked source, and then adding a pending slot 5, shows that the raise lifts a source above the I-gated group only and never above the X-gated or unmaskable slots. Odd, out-of-range and locked-out raise values show that invalid settings fall back to the fixed order. A long stretch of seeded random events, writes, mask changes and acknowledges is then compared cycle by cycle against a bench model of flags, enables, the raise register, the latched vector and the read data. This exposes collisions between set and clear and races between acknowledge and a change of mask.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam logic [15:0] VEC_TOP        = 16'hFFFE;
  localparam int          X_SLOT         = 5;
  localparam int          FIRST_MASKABLE = 6;
  localparam logic [7:0]  RAISE_RESET    = 8'hF2;

  typedef enum logic [1:0] {
    RA_FLAGS  = 2'd0,
    RA_ENABLE = 2'd1,
    RA_RAISE  = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  function automatic logic [15:0] slot_vector(input int unsigned slot);
    return VEC_TOP - 16'(2 * slot);
  endfunction
endpackage

// File: rtl/ivc_src_regs.sv
module ivc_src_regs #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] en_q
);
  import ivc_pkg::*;

  logic flag_wr;
  logic en_wr;
  assign flag_wr = wr_en && (wr_addr == RA_FLAGS);
  assign en_wr   = wr_en && (wr_addr == RA_ENABLE);

  for (genvar k = 0; k < N; k++) begin : g_flag
    logic clr;
    assign clr = flag_wr && wdata[k];
    always_ff @(posedge clk) begin
      if (rst)         flag_q[k] <= 1'b0;
      else if (evt[k]) flag_q[k] <= 1'b1;
      else if (clr)    flag_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_wr) en_q <= wdata;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((($past(flag_q) & ~$past((wr_en && wr_addr == RA_FLAGS) ? wdata : '0)) & ~flag_q) == '0)); // R2
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    (($past(evt) & ~flag_q) == '0)); // R2
endmodule

// File: rtl/ivc_raise.sv
module ivc_raise #(
  parameter int N  = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wdata,
  input  logic          i_mask,
  output logic [7:0]    raise_q,
  output logic          raise_valid,
  output logic [SW-1:0] raise_slot
);
  import ivc_pkg::*;

  logic [7:0] slot_raw;

  always_ff @(posedge clk) begin
    if (rst)
      raise_q <= RAISE_RESET;
    else if (wr_en && wr_addr == RA_RAISE && i_mask)
      raise_q <= wdata;
  end

  always_comb begin
    slot_raw    = (8'hFE - raise_q) >> 1;
    raise_valid = !raise_q[0] && (int'(slot_raw) >= FIRST_MASKABLE)
                  && (int'(slot_raw) < N);
    raise_slot  = SW'(slot_raw);
  end

  AST_RAISE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !$past(i_mask) |-> $stable(raise_q)); // R8
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int N  = 16,
  parameter int SW = 4
) (
  input  logic [N-1:0]  pend,
  input  logic          raise_valid,
  input  logic [SW-1:0] raise_slot,
  output logic          win_valid,
  output logic [SW-1:0] win_slot
);
  import ivc_pkg::*;

  logic upper_pend;
  assign upper_pend = |pend[FIRST_MASKABLE-1:0];

  always_comb begin
    win_valid = 1'b0;
    win_slot  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend[k]) begin
        win_valid = 1'b1;
        win_slot  = SW'(k);
      end
    end
    if (!upper_pend && raise_valid && pend[raise_slot])
      win_slot = raise_slot;
  end

  always_comb begin
    AST_WIN_PENDING: assert (!win_valid || pend[win_slot]); // R5
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               i_mask,
  input  logic               x_mask,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] rd_data,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [15:0]        irq_vec
);
  import ivc_pkg::*;

  localparam int SW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] flag_q, en_q, gate, pend;
  logic [7:0]         raise_q;
  logic               raise_valid, win_valid;
  logic [SW-1:0]      raise_slot, win_slot;

  ivc_src_regs #(.N(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .evt(evt), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wdata(reg_wdata), .flag_q(flag_q), .en_q(en_q)
  );

  ivc_raise #(.N(NUM_SRC), .SW(SW)) u_raise (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wdata(reg_wdata[7:0]), .i_mask(i_mask), .raise_q(raise_q),
    .raise_valid(raise_valid), .raise_slot(raise_slot)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_gate
    if (k < X_SLOT)       begin : g_nmi assign gate[k] = 1'b1;    end
    else if (k == X_SLOT) begin : g_x   assign gate[k] = !x_mask; end
    else                  begin : g_i   assign gate[k] = !i_mask; end
  end

  assign pend    = flag_q & en_q & gate;
  assign irq_req = |pend;

  ivc_arbiter #(.N(NUM_SRC), .SW(SW)) u_arb (
    .pend(pend), .raise_valid(raise_valid), .raise_slot(raise_slot),
    .win_valid(win_valid), .win_slot(win_slot)
  );

  always_ff @(posedge clk) begin
    if (rst)
      irq_vec <= VEC_TOP;
    else if (irq_ack && win_valid)
      irq_vec <= slot_vector(int'(win_slot));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (reg_addr)
        RA_FLAGS:  rd_data <= flag_q;
        RA_ENABLE: rd_data <= en_q;
        RA_RAISE:  rd_data <= {{(NUM_SRC-8){1'b0}}, raise_q};
        default:   rd_data <= '0;
      endcase
    end
  end

  AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((flag_q & en_q) != '0)); // R4
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(irq_ack && irq_req) |-> $stable(irq_vec)); // R10
  AST_RAISED_WINS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && raise_valid && pend[raise_slot] && (pend[FIRST_MASKABLE-1:0] == '0))
    |=> (irq_vec == slot_vector(int'($past(raise_slot))))); // R6
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int N = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] evt = '0, reg_wdata = '0, rd_data;
  logic i_mask = 1'b1, x_mask = 1'b1, reg_wr = 1'b0, irq_ack = 1'b0, irq_req;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] irq_vec;

  int n_chk = 0, n_err = 0;
  logic [N-1:0] m_flag, m_en, m_rd;
  logic [7:0] m_raise;
  logic [15:0] m_vec;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NUM_SRC(N)) dut (
    .clk(clk), .rst(rst), .evt(evt), .i_mask(i_mask), .x_mask(x_mask),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int model_win(input logic [N-1:0] f, input logic [N-1:0] e,
                                   input logic im, input logic xm, input logic [7:0] rv);
    logic [N-1:0] p;
    int rs;
    for (int k = 0; k < N; k++)
      p[k] = f[k] && e[k] && ((k < 5) || (k == 5 && !xm) || (k > 5 && !im));
    for (int k = 0; k < 6; k++) if (p[k]) return k;
    rs = (8'hFE - int'(rv)) / 2;
    if (!rv[0] && int'(rv) <= 8'hFE && rs >= 6 && rs < N && p[rs]) return rs;
    for (int k = 6; k < N; k++) if (p[k]) return k;
    return -1;
  endfunction

  // One clock: update the model with the pre-edge state, then compare at the falling edge.
  task automatic cycle();
    int w;
    @(posedge clk);
    w = model_win(m_flag, m_en, i_mask, x_mask, m_raise);
    if (irq_ack && w >= 0) m_vec = 16'hFFFE - 16'(2 * w);
    case (reg_addr)
      2'd0: m_rd = m_flag;
      2'd1: m_rd = m_en;
      2'd2: m_rd = {{(N-8){1'b0}}, m_raise};
      default: m_rd = '0;
    endcase
    m_flag = (m_flag & ~((reg_wr && reg_addr == 2'd0) ? reg_wdata : '0)) | evt;
    if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata;
    if (reg_wr && reg_addr == 2'd2 && i_mask) m_raise = reg_wdata[7:0];
    @(negedge clk);
    chk("R4 request", {15'd0, irq_req},
        {15'd0, model_win(m_flag, m_en, i_mask, x_mask, m_raise) >= 0});
    chk("R5 vector", irq_vec, m_vec);
    chk("R9 readback", rd_data, m_rd);
  endtask

  task automatic idle();
    evt = '0; reg_wr = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cycle(); idle();
  endtask

  task automatic rd(input logic [1:0] a);
    reg_addr = a; cycle();
  endtask

  task automatic pulse(input logic [N-1:0] e);
    evt = e; cycle(); idle();
  endtask

  task automatic ack();
    irq_ack = 1'b1; cycle(); idle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_flag = '0; m_en = '0; m_raise = 8'hF2; m_vec = 16'hFFFE; m_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 req", {15'd0, irq_req}, 16'h0);
    chk("R1 vec", irq_vec, 16'hFFFE);
    rd(2'd0); chk("R1 flags", rd_data, 16'h0);
    rd(2'd1); chk("R1 enables", rd_data, 16'h0);
    rd(2'd2); chk("R1 raise", rd_data, 16'h00F2);

    // R3 enables
    wr(2'd1, 16'h02E0);
    rd(2'd1); chk("R3 enable readback", rd_data, 16'h02E0);

    // R2 set, write-0 no effect, write-1 clear, set beats clear
    pulse(16'h0080);
    rd(2'd0); chk("R2 event sets", rd_data, 16'h0080);
    wr(2'd0, 16'h0000);
    rd(2'd0); chk("R2 write0 keeps", rd_data, 16'h0080);
    wr(2'd0, 16'h0080);
    rd(2'd0); chk("R2 write1 clears", rd_data, 16'h0000);
    evt = 16'h0200; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0200;
    cycle(); idle();
    rd(2'd0); chk("R2 set wins", rd_data, 16'h0200);

    // R4 gating by i_mask and x_mask
    chk("R4 masked quiet", {15'd0, irq_req}, 16'h0);
    i_mask = 1'b0; cycle();
    chk("R4 unmasked request", {15'd0, irq_req}, 16'h1);
    i_mask = 1'b1; pulse(16'h0020); cycle();
    chk("R4 x masked", {15'd0, irq_req}, 16'h0);
    x_mask = 1'b0; cycle();
    chk("R4 x open", {15'd0, irq_req}, 16'h1);
    wr(2'd0, 16'h0020); x_mask = 1'b1;

    // R5 fixed order: slots 6, 7, 9 pending
    pulse(16'h00C0); i_mask = 1'b0;
    ack(); chk("R5 lowest slot wins", irq_vec, 16'hFFF2);
    wr(2'd0, 16'h0040);
    ack(); chk("R5 next slot", irq_vec, 16'hFFF0);

    // R8 raise write dropped while unmasked
    wr(2'd2, 16'h00F6);
    rd(2'd2); chk("R8 write dropped", rd_data, 16'h00F2);

    // R6 raise slot 7 above slot 6, but not above slot 5
    i_mask = 1'b1; wr(2'd2, 16'h00F0); pulse(16'h0040); i_mask = 1'b0;
    ack(); chk("R6 raised wins", irq_vec, 16'hFFF0);
    pulse(16'h0020); x_mask = 1'b0;
    ack(); chk("R6 x slot above raised", irq_vec, 16'hFFF4);
    wr(2'd0, 16'h0020); x_mask = 1'b1;

    // R7 invalid raise values
    i_mask = 1'b1; wr(2'd2, 16'h00F1); i_mask = 1'b0;
    ack(); chk("R7 odd ignored", irq_vec, 16'hFFF2);
    rd(2'd2); chk("R7 readback", rd_data, 16'h00F1);
    i_mask = 1'b1; wr(2'd2, 16'h00F0); i_mask = 1'b0; ack();
    i_mask = 1'b1; wr(2'd2, 16'h00F4); i_mask = 1'b0;
    ack(); chk("R7 slot5 ignored", irq_vec, 16'hFFF2);
    i_mask = 1'b1; wr(2'd2, 16'h00DE); i_mask = 1'b0;
    ack(); chk("R7 out of range ignored", irq_vec, 16'hFFF2);

    // R10 acknowledge with nothing requesting
    i_mask = 1'b1; cycle();
    chk("R10 no request", {15'd0, irq_req}, 16'h0);
    ack(); chk("R10 vec held", irq_vec, 16'hFFF2);

    // R9 unused address
    rd(2'd3); chk("R9 unused reads zero", rd_data, 16'h0);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      evt      = N'($urandom & $urandom & $urandom);
      reg_wr   = ($urandom % 4) == 0;
      reg_addr = 2'($urandom);
      reg_wdata = N'($urandom);
      if (reg_addr == 2'd2 && ($urandom % 2)) reg_wdata = N'(8'hE0 + 2 * ($urandom % 10));
      i_mask   = ($urandom % 3) == 0;
      x_mask   = ($urandom % 2) == 0;
      irq_ack  = ($urandom % 3) == 0;
      cycle();
    end
    idle();

    summary();
    $finish;
  end
endmodule